// File: doc/BRIEF.md
# Adder-Based Bank Memory Mapper

This block sits between a CPU with a 16-bit address bus and a 512K RAM plus a 32K ROM. It splits the logical space into eight 8K pages. The top three logical address bits give the page number. An 8-bit base register is added to that page number, and the low six bits of the sum become the physical page. Moving the base therefore moves a window over the larger RAM. The highest logical page does not take part in this addition. It always lands on the highest physical page, so every bank sees the same common area. With the base stepped in units of seven pages, the RAM below the common page holds nine full 56K banks.

A ROM overlay covers the lower half of the logical space while its enable flag is set. Reset sets that flag and clears the base. Boot code can then copy itself into the common page, jump there, and clear the flag by an I/O write. The common page does not move when the flag changes. The address path and the chip selects are purely combinational. The only state is the two I/O-written registers. `paddr_o` is the RAM address. The ROM takes its address from `laddr_i[14:0]`.

Top module: `bank_mapper`

## Requirements
- R1: `paddr_o[12:0]` always equals `laddr_i[12:0]`, and the logical page number is `laddr_i[15:13]`.
- R2: For logical pages 0 to 6, `paddr_o[18:13]` equals bits [5:0] of the 8-bit sum base + page. Any carry above bit 5 is discarded, so the result wraps modulo 64.
- R3: For logical page 7, `paddr_o[18:13]` is 6'h3F, whatever the base or the ROM flag.
- R4: After reset the base is 0 and the ROM flag is 1.
- R5: An I/O write (`io_wr_i`=1 at a rising clock edge) loads the base from `io_data_i` when `io_addr_i`=8'h78. It loads the ROM flag from `io_data_i[0]` when `io_addr_i`=8'h7C. Writes to any other port change neither register.
- R6: With the ROM flag set, a read (`mem_req_i`=1, `mem_rd_i`=1) with `laddr_i[15]`=0 asserts `rom_cs_o` and deasserts `ram_cs_o`.
- R7: With the ROM flag set, a write (`mem_wr_i`=1) with `laddr_i[15]`=0 asserts neither chip select.
- R8: When the ROM flag is clear, or `laddr_i[15]`=1, an active memory request asserts `ram_cs_o` and never `rom_cs_o`.
- R9: With `mem_req_i`=0 both chip selects are 0, and the two selects are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the I/O-written registers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| laddr_i | input | 16 | CPU logical address |
| mem_req_i | input | 1 | Memory request active |
| mem_rd_i | input | 1 | Memory read cycle |
| mem_wr_i | input | 1 | Memory write cycle |
| io_wr_i | input | 1 | I/O write strobe |
| io_addr_i | input | 8 | I/O port address (low address byte) |
| io_data_i | input | 8 | I/O write data |
| paddr_o | output | 19 | Physical RAM address |
| ram_cs_o | output | 1 | RAM chip select, active high |
| rom_cs_o | output | 1 | ROM chip select, active high |

## Verification
The bench drives bases whose sum with the page number carries past bit 5 and past bit 7. A mapper that kept the carry, or that used a narrower adder, would put those pages in the wrong place. It sets large bases together with page 7, both before and after the ROM flag is cleared. A design that added the base to the common page would move shared code while banks are switched. It also tries writes into the ROM window, which must select nothing: a wrong decode would drive the ROM or corrupt the RAM hidden under it. Finally, it writes to ports next to the two decoded addresses. A loose port decode would then overwrite the base.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  localparam int unsigned IO_AW = 8;
  localparam int unsigned IO_DW = 8;

  // Wrapping add of base and logical page at adder width
  function automatic logic [IO_DW-1:0] page_add(input logic [IO_DW-1:0] base,
                                                input logic [IO_DW-1:0] page);
    return base + page;
  endfunction
endpackage

// File: rtl/bank_regs.sv
module bank_regs
  import bank_map_pkg::*;
#(
  parameter logic [IO_AW-1:0] BASE_PORT = 8'h78,
  parameter logic [IO_AW-1:0] ROM_PORT  = 8'h7C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             io_wr_i,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic [IO_DW-1:0] io_data_i,
  output logic [IO_DW-1:0] base_o,
  output logic             rom_en_o
);
  logic base_we, rom_we;
  assign base_we = io_wr_i && (io_addr_i == BASE_PORT);
  assign rom_we  = io_wr_i && (io_addr_i == ROM_PORT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o   <= '0;
      rom_en_o <= 1'b1;
    end else begin
      if (base_we) base_o   <= io_data_i;
      if (rom_we)  rom_en_o <= io_data_i[0];
    end
  end

  // R5
  base_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_i && io_addr_i == BASE_PORT |=> base_o == $past(io_data_i));
  // R5
  base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wr_i && io_addr_i == BASE_PORT) |=> $stable(base_o));
  // R5
  rom_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wr_i && io_addr_i == ROM_PORT) |=> $stable(rom_en_o));
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import bank_map_pkg::*;
#(
  parameter int unsigned LADDR_W = 16,
  parameter int unsigned PAGE_W  = 3,
  parameter int unsigned PPAGE_W = 6,
  localparam int unsigned OFF_W   = LADDR_W - PAGE_W,
  localparam int unsigned PADDR_W = PPAGE_W + OFF_W
) (
  input  logic [IO_DW-1:0]   base_i,
  input  logic [LADDR_W-1:0] laddr_i,
  output logic [PADDR_W-1:0] paddr_o
);
  logic [PAGE_W-1:0]  lpage;
  logic [IO_DW-1:0]   sum;
  logic [PPAGE_W-1:0] ppage;
  logic               unused_sum_hi;

  assign lpage = laddr_i[LADDR_W-1 -: PAGE_W];
  assign sum   = page_add(base_i, IO_DW'(lpage));
  assign unused_sum_hi = ^sum[IO_DW-1:PPAGE_W];

  // Top logical page pinned to top physical page (common area)
  assign ppage   = (&lpage) ? {PPAGE_W{1'b1}} : sum[PPAGE_W-1:0];
  assign paddr_o = {ppage, laddr_i[OFF_W-1:0]};
endmodule

// File: rtl/cs_decode.sv
module cs_decode #(
  parameter int unsigned LADDR_W = 16,
  parameter int unsigned ROM_AW  = 15
) (
  input  logic               mem_req_i,
  input  logic               mem_rd_i,
  input  logic               mem_wr_i,
  input  logic               rom_en_i,
  input  logic [LADDR_W-1:0] laddr_i,
  output logic               ram_cs_o,
  output logic               rom_cs_o
);
  logic in_rom_win;
  logic unused_wr;

  assign in_rom_win = rom_en_i && (laddr_i[LADDR_W-1:ROM_AW] == '0);
  assign unused_wr  = mem_wr_i;
  // Writes into an enabled ROM window select nothing
  assign rom_cs_o = mem_req_i && in_rom_win && mem_rd_i;
  assign ram_cs_o = mem_req_i && !in_rom_win;
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_map_pkg::*;
#(
  parameter int unsigned LADDR_W = 16,
  parameter int unsigned PAGE_W  = 3,
  parameter int unsigned PPAGE_W = 6,
  parameter int unsigned ROM_AW  = 15,
  parameter logic [IO_AW-1:0] BASE_PORT = 8'h78,
  parameter logic [IO_AW-1:0] ROM_PORT  = 8'h7C,
  localparam int unsigned PADDR_W = PPAGE_W + LADDR_W - PAGE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LADDR_W-1:0] laddr_i,
  input  logic               mem_req_i,
  input  logic               mem_rd_i,
  input  logic               mem_wr_i,
  input  logic               io_wr_i,
  input  logic [IO_AW-1:0]   io_addr_i,
  input  logic [IO_DW-1:0]   io_data_i,
  output logic [PADDR_W-1:0] paddr_o,
  output logic               ram_cs_o,
  output logic               rom_cs_o
);
  localparam int unsigned OFF_W = LADDR_W - PAGE_W;

  logic [IO_DW-1:0] base;
  logic             rom_en;

  bank_regs #(.BASE_PORT(BASE_PORT), .ROM_PORT(ROM_PORT)) u_regs (
    .clk_i, .rst_ni, .io_wr_i, .io_addr_i, .io_data_i,
    .base_o(base), .rom_en_o(rom_en)
  );

  page_xlate #(.LADDR_W(LADDR_W), .PAGE_W(PAGE_W), .PPAGE_W(PPAGE_W)) u_xlate (
    .base_i(base), .laddr_i, .paddr_o
  );

  cs_decode #(.LADDR_W(LADDR_W), .ROM_AW(ROM_AW)) u_cs (
    .mem_req_i, .mem_rd_i, .mem_wr_i, .rom_en_i(rom_en), .laddr_i,
    .ram_cs_o, .rom_cs_o
  );

  // R1
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paddr_o[OFF_W-1:0] == laddr_i[OFF_W-1:0]);
  // R3
  common_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &laddr_i[LADDR_W-1 -: PAGE_W] |-> &paddr_o[PADDR_W-1:OFF_W]);
  // R7
  rom_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_cs_o |-> mem_rd_i && !laddr_i[LADDR_W-1]);
  // R9
  cs_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_i |-> !ram_cs_o && !rom_cs_o);
  // R9
  cs_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_cs_o, rom_cs_o}));
  // R8
  upper_ram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && laddr_i[LADDR_W-1] |-> ram_cs_o);
endmodule

// File: tb/bank_mapper_tb.sv
module bank_mapper_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] laddr_i = '0;
  logic        mem_req_i = 1'b0, mem_rd_i = 1'b0, mem_wr_i = 1'b0;
  logic        io_wr_i = 1'b0;
  logic [7:0]  io_addr_i = '0, io_data_i = '0;
  logic [18:0] paddr_o;
  logic        ram_cs_o, rom_cs_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  bank_mapper u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [7:0] port, logic [7:0] data);
    @(negedge clk_i);
    io_wr_i = 1'b1; io_addr_i = port; io_data_i = data;
    @(posedge clk_i); #1;
    io_wr_i = 1'b0;
  endtask

  // Drive a memory cycle and settle combinational outputs
  task automatic mem(logic [15:0] a, logic rd, logic wr, logic req = 1'b1);
    @(negedge clk_i);
    laddr_i = a; mem_rd_i = rd; mem_wr_i = wr; mem_req_i = req;
    #1;
  endtask

  function automatic logic [18:0] exp_pa(logic [7:0] base, logic [15:0] a);
    logic [7:0] s;
    s = base + {5'b0, a[15:13]};
    if (a[15:13] == 3'b111) return {6'h3F, a[12:0]};
    return {s[5:0], a[12:0]};
  endfunction

  task automatic t_reset();
    mem(16'h0123, 1, 0);
    chk("R4 rom on after reset", {rom_cs_o, ram_cs_o}, 2'b10);
    mem(16'h8456, 1, 0);
    chk("R4 base zero after reset", paddr_o, 19'h08456);
  endtask

  task automatic t_translate();
    io_write(8'h7C, 8'h00);
    io_write(8'h78, 8'd7);
    mem(16'h4123, 1, 0);
    chk("R1 R2 base 7 page 2", paddr_o, exp_pa(8'd7, 16'h4123));
    chk("R1 offset", paddr_o[12:0], 13'h0123);
    io_write(8'h78, 8'h3E);
    mem(16'h7ABC, 0, 1);
    chk("R2 carry past bit 5", paddr_o, exp_pa(8'h3E, 16'h7ABC));
    io_write(8'h78, 8'hFF);
    mem(16'h2001, 1, 0);
    chk("R2 carry past bit 7", paddr_o, exp_pa(8'hFF, 16'h2001));
    io_write(8'h78, 8'd56);
    mem(16'hC000, 1, 0);
    chk("R2 ninth bank page 6", paddr_o, {6'd62, 13'h0});
  endtask

  task automatic t_common();
    io_write(8'h78, 8'h10);
    mem(16'hE456, 1, 0);
    chk("R3 common page", paddr_o, 19'h7E456);
    io_write(8'h7C, 8'h01);
    mem(16'hFFFF, 0, 1);
    chk("R3 common page rom on", paddr_o, 19'h7FFFF);
    chk("R8 common page ram", {rom_cs_o, ram_cs_o}, 2'b01);
  endtask

  task automatic t_ports();
    io_write(8'h78, 8'h05);
    io_write(8'h79, 8'h20);
    io_write(8'h77, 8'h20);
    mem(16'h8000, 1, 0);
    chk("R5 neighbour ports ignored", paddr_o, {6'd9, 13'h0});
    io_write(8'h7D, 8'h00);
    mem(16'h1000, 1, 0);
    chk("R5 rom flag unchanged", {rom_cs_o, ram_cs_o}, 2'b10);
  endtask

  task automatic t_rom();
    io_write(8'h7C, 8'h01);
    mem(16'h7FFF, 1, 0);
    chk("R6 rom read top of window", {rom_cs_o, ram_cs_o}, 2'b10);
    mem(16'h0000, 0, 1);
    chk("R7 write into rom window", {rom_cs_o, ram_cs_o}, 2'b00);
    mem(16'h8000, 1, 0);
    chk("R8 above window", {rom_cs_o, ram_cs_o}, 2'b01);
    io_write(8'h7C, 8'hFE);
    mem(16'h0000, 1, 0);
    chk("R8 rom off read", {rom_cs_o, ram_cs_o}, 2'b01);
    mem(16'h0000, 0, 1);
    chk("R8 rom off write", {rom_cs_o, ram_cs_o}, 2'b01);
  endtask

  task automatic t_idle();
    io_write(8'h7C, 8'h01);
    mem(16'h0000, 1, 0, 1'b0);
    chk("R9 idle low window", {rom_cs_o, ram_cs_o}, 2'b00);
    mem(16'hA000, 1, 0, 1'b0);
    chk("R9 idle high", {rom_cs_o, ram_cs_o}, 2'b00);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_translate();
    t_common();
    t_ports();
    t_rom();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule